// File: doc/BRIEF.md
# Status Register and Write Guard

This block keeps the status register of a serial nonvolatile memory. It holds the write-enable latch and it decides whether a write may start. The serial front end has already framed each command. It reports a command to this block when chip select rises. That report carries a kind code and the number of bits that were clocked in. The block then either starts an internal write cycle or leaves everything unchanged. The cycle may be an array write or a status write. While a cycle runs the block shows busy until a done pulse arrives. It also answers a combinational query: given a target address and a write type, it says whether that write would be allowed right now.

The nonvolatile part of the register has three fields. The first is the pin-enable bit (`pin_en`). The other two are the zone bits, which select how much of the top of the array is guarded. These fields are cleared only by the power-on reset. A soft reset clears only the volatile state: the latch and any cycle in flight.

The control is a five-state machine:
- `ST_IDLE` waits for framed commands.
- `ST_ARMED` is entered on `sr_loaded`, when a status data byte has been captured while select is still low.
- `ST_DROPPED` is entered from `ST_ARMED` if the hardware lock asserts during that window.
- `ST_ARR_BUSY` and `ST_SR_BUSY` hold the two kinds of internal cycle.

The transitions are:
- idle→armed on `sr_loaded`.
- idle→arr_busy on an accepted array write.
- armed→sr_busy on an accepted status write.
- armed→idle on any other frame end.
- armed→dropped on the hardware lock.
- dropped→idle on frame end.
- Both busy states return to idle on `wr_done`.
- Any state goes to idle on the soft reset.

Top module: `sbp_status_guard`

## Requirements
- R1: After the power-on reset `status_byte` reads 0x00. When no cycle is running it reads {pin_en, 3'b000, zone[1:0], wel, 1'b0}, with pin_en at bit 7, zone at bits 3:2, the latch at bit 1 and busy at bit 0.
- R2: The frame kind codes are 1 enable, 2 disable, 3 status write and 4 array write. An enable frame sets the latch only when exactly 8 bits were clocked. Any other bit count leaves the latch unchanged.
- R3: A disable frame with exactly 8 bits clears the latch.
- R4: An array write frame starts a cycle only when all of these hold:
  - the frame has at least 32 bits, and the count is a multiple of 8;
  - the latch is set;
  - `wr_addr` is outside the guarded zone.
  The cycle shows as busy from the next cycle. Otherwise nothing changes.
- R5: The guarded zone for the 13-bit address is set by the zone bits: 00 none, 01 0x1800–0x1FFF, 10 0x1000–0x1FFF, 11 all addresses. A guarded address is always refused, whatever the latch, pin and pin_en. `q_allow` for an array query is the latch ANDed with "not guarded".
- R6: The hardware lock (`hw_lock`) is set when pin_en=1 and `lock_pin_n` is low. Under the lock, status writes are refused and `q_allow` for a status query is 0. Array writes outside the zone stay allowed.
- R7: A status write has two steps: `sr_loaded` arms it, and a status frame of exactly 16 bits ends it. If the lock asserts at any time while it is armed, the write is dropped. This holds even if the pin returns high before the frame ends.
- R8: While a cycle runs, `status_byte` reads 0xFF and every framed command is ignored.
- R9: `wr_done` ends the cycle and clears the latch. A status cycle then loads only bits 7, 3 and 2 of the captured byte into pin_en and the zone bits.
- R10: The soft reset clears the latch and any armed or running cycle but keeps pin_en and the zone bits. The power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, async, active low, clears all state |
| soft_rst_n | input | 1 | Soft reset, sync, active low, clears volatile state |
| lock_pin_n | input | 1 | Write-lock pin, low requests the hardware lock |
| frame_end | input | 1 | One-cycle pulse: select rose, a command frame ended |
| frame_kind | input | 3 | Kind code of the ended frame |
| frame_bits | input | FBW (10) | Number of bits clocked in the frame |
| sr_loaded | input | 1 | Pulse: status data byte captured, select still low |
| sr_data | input | 8 | Captured status data byte |
| wr_addr | input | AW (13) | Start address of the array write frame |
| wr_done | input | 1 | Pulse: the internal write cycle has finished |
| q_addr | input | AW (13) | Query target address |
| q_status | input | 1 | Query write type: 1 status, 0 array |
| q_allow | output | 1 | Query result: 1 allowed |
| status_byte | output | 8 | Readable status byte |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Internal write cycle running |
| hw_lock | output | 1 | Hardware lock active |
| arr_cycle | output | 1 | Array write cycle running |
| sr_cycle | output | 1 | Status write cycle running |

## Verification
Several internal faults show up at the ports one cycle after the frame or pulse that triggers them:
- A latch stuck in the wrong state appears at once in bit 1 of `status_byte` and in `q_allow`.
- A wrong zone decode appears in `q_allow` in the same cycle as the query. A write to a guarded address would also raise busy on the following edge.
- A state machine that skips the drop after an armed write saw the lock commits that write. This shows as 0xFF on the status byte one cycle after the frame end, and as changed nonvolatile bits after the done pulse.
- Nonvolatile bits lost on a soft reset are visible in the first cycle after that reset.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [2:0] {
        FK_NONE = 3'd0,
        FK_EN   = 3'd1,
        FK_DIS  = 3'd2,
        FK_SR   = 3'd3,
        FK_ARR  = 3'd4
    } frame_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARMED    = 3'd1,
        ST_DROPPED  = 3'd2,
        ST_ARR_BUSY = 3'd3,
        ST_SR_BUSY  = 3'd4
    } guard_state_t;

    localparam int ZONE_W = 2;

endpackage

// File: rtl/sbp_zone_dec.sv
module sbp_zone_dec #(
    parameter int AW = 13
) (
    input  logic [1:0]    zone,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    // Top quarter, top half or the whole array, selected by the zone bits.
    logic top_quarter;
    logic top_half;

    assign top_quarter = &addr[AW-1:AW-2];
    assign top_half    = addr[AW-1];

    always_comb begin
        unique case (zone)
            2'b00:   hit = 1'b0;
            2'b01:   hit = top_quarter;
            2'b10:   hit = top_half;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sbp_nvbits.sv
module sbp_nvbits (
    input  logic       clk,
    input  logic       por_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       pin_en,
    output logic [1:0] zone
);
    // Survive the soft reset: only the power-on reset clears them.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pin_en <= 1'b0;
            zone   <= 2'b00;
        end else if (load) begin
            pin_en <= din[7];
            zone   <= din[3:2];
        end
    end
endmodule

// File: rtl/sbp_fsm.sv
module sbp_fsm
    import sbp_pkg::*;
#(
    parameter int FBW = 10
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           soft_rst_n,
    input  logic           frame_end,
    input  logic [2:0]     frame_kind,
    input  logic [FBW-1:0] frame_bits,
    input  logic           sr_loaded,
    input  logic [7:0]     sr_data,
    input  logic           hw_lock,
    input  logic           arr_hit,
    input  logic           wr_done,
    output logic           wel,
    output logic           wip,
    output logic           arr_cycle,
    output logic           sr_cycle,
    output logic           nv_load,
    output logic [7:0]     nv_data
);
    localparam logic [FBW-1:0] OP_BITS  = FBW'(8);
    localparam logic [FBW-1:0] SR_BITS  = FBW'(16);
    localparam logic [FBW-1:0] MIN_ARR  = FBW'(32);

    guard_state_t state, nxt;
    logic [7:0]   sr_hold;

    logic en_ok, dis_ok, arr_ok, sr_ok;

    always_comb begin
        en_ok  = frame_end && (frame_kind == FK_EN)  && (frame_bits == OP_BITS);
        dis_ok = frame_end && (frame_kind == FK_DIS) && (frame_bits == OP_BITS);
        arr_ok = frame_end && (frame_kind == FK_ARR) && (frame_bits >= MIN_ARR)
                 && (frame_bits[2:0] == 3'b000) && wel && !arr_hit;
        sr_ok  = frame_end && (frame_kind == FK_SR) && (frame_bits == SR_BITS)
                 && wel && !hw_lock;
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_loaded)   nxt = ST_ARMED;
                else if (arr_ok) nxt = ST_ARR_BUSY;
            end
            ST_ARMED: begin
                if (hw_lock)        nxt = ST_DROPPED;
                else if (sr_ok)     nxt = ST_SR_BUSY;
                else if (frame_end) nxt = ST_IDLE;
            end
            ST_DROPPED:  if (frame_end) nxt = ST_IDLE;
            ST_ARR_BUSY: if (wr_done)   nxt = ST_IDLE;
            ST_SR_BUSY:  if (wr_done)   nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)           state <= ST_IDLE;
        else if (!soft_rst_n) state <= ST_IDLE;
        else                  state <= nxt;
    end

    // Write-enable latch
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)           wel <= 1'b0;
        else if (!soft_rst_n) wel <= 1'b0;
        else if ((state == ST_ARR_BUSY || state == ST_SR_BUSY) && wr_done)
            wel <= 1'b0;
        else if (state == ST_IDLE && en_ok)
            wel <= 1'b1;
        else if (state == ST_IDLE && dis_ok)
            wel <= 1'b0;
    end

    // Captured status byte, held until the cycle completes
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                              sr_hold <= 8'h00;
        else if (state == ST_IDLE && sr_loaded)  sr_hold <= sr_data;
    end

    // Outputs
    always_comb begin
        arr_cycle = 1'b0;
        sr_cycle  = 1'b0;
        nv_load   = 1'b0;
        unique case (state)
            ST_ARR_BUSY: arr_cycle = 1'b1;
            ST_SR_BUSY: begin
                sr_cycle = 1'b1;
                nv_load  = wr_done && soft_rst_n;
            end
            default: ;
        endcase
        wip     = arr_cycle | sr_cycle;
        nv_data = sr_hold;
    end
endmodule

// File: rtl/sbp_status_guard.sv
module sbp_status_guard
    import sbp_pkg::*;
#(
    parameter int AW  = 13,
    parameter int FBW = 10
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           soft_rst_n,
    input  logic           lock_pin_n,
    input  logic           frame_end,
    input  logic [2:0]     frame_kind,
    input  logic [FBW-1:0] frame_bits,
    input  logic           sr_loaded,
    input  logic [7:0]     sr_data,
    input  logic [AW-1:0]  wr_addr,
    input  logic           wr_done,
    input  logic [AW-1:0]  q_addr,
    input  logic           q_status,
    output logic           q_allow,
    output logic [7:0]     status_byte,
    output logic           wel,
    output logic           wip,
    output logic           hw_lock,
    output logic           arr_cycle,
    output logic           sr_cycle
);
    logic       pin_en;
    logic [1:0] zone;
    logic       nv_load;
    logic [7:0] nv_data;
    logic       wr_hit, q_hit;

    sbp_nvbits u_nv (
        .clk    (clk),
        .por_n  (por_n),
        .load   (nv_load),
        .din    (nv_data),
        .pin_en (pin_en),
        .zone   (zone)
    );

    assign hw_lock = pin_en && !lock_pin_n;

    sbp_zone_dec #(.AW(AW)) u_wr_zone (.zone(zone), .addr(wr_addr), .hit(wr_hit));
    sbp_zone_dec #(.AW(AW)) u_q_zone  (.zone(zone), .addr(q_addr),  .hit(q_hit));

    sbp_fsm #(.FBW(FBW)) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .soft_rst_n (soft_rst_n),
        .frame_end  (frame_end),
        .frame_kind (frame_kind),
        .frame_bits (frame_bits),
        .sr_loaded  (sr_loaded),
        .sr_data    (sr_data),
        .hw_lock    (hw_lock),
        .arr_hit    (wr_hit),
        .wr_done    (wr_done),
        .wel        (wel),
        .wip        (wip),
        .arr_cycle  (arr_cycle),
        .sr_cycle   (sr_cycle),
        .nv_load    (nv_load),
        .nv_data    (nv_data)
    );

    assign q_allow     = wel && !wip && (q_status ? !hw_lock : !q_hit);
    assign status_byte = wip ? 8'hFF : {pin_en, 3'b000, zone, wel, 1'b0};
endmodule

// File: rtl/sbp_status_guard_chk.sv
module sbp_status_guard_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          por_n,
    input logic          soft_rst_n,
    input logic          q_status,
    input logic [AW-1:0] q_addr,
    input logic          q_allow,
    input logic [7:0]    status_byte,
    input logic          wel,
    input logic          wip,
    input logic          hw_lock,
    input logic          arr_cycle,
    input logic          sr_cycle
);
    // R8
    busy_ones_chk: assert property (@(posedge clk) disable iff (!por_n)
        wip |-> status_byte == 8'hFF);

    // R4
    arr_needs_wel_chk: assert property (@(posedge clk) disable iff (!por_n || !soft_rst_n)
        $rose(arr_cycle) |-> $past(wel));

    // R6
    sr_lock_chk: assert property (@(posedge clk) disable iff (!por_n || !soft_rst_n)
        $rose(sr_cycle) |-> ($past(wel) && !$past(hw_lock)));

    // R5
    zone_all_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wip && status_byte[3:2] == 2'b11 && !q_status) |-> !q_allow);

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!por_n || !soft_rst_n)
        $fell(wip) |-> !wel);

    // R10
    nv_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wip && !$past(wip)) |-> ($stable(status_byte[7]) && $stable(status_byte[3:2])));

    // R8
    one_cycle_kind_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(arr_cycle && sr_cycle));
endmodule

bind sbp_status_guard sbp_status_guard_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .soft_rst_n  (soft_rst_n),
    .q_status    (q_status),
    .q_addr      (q_addr),
    .q_allow     (q_allow),
    .status_byte (status_byte),
    .wel         (wel),
    .wip         (wip),
    .hw_lock     (hw_lock),
    .arr_cycle   (arr_cycle),
    .sr_cycle    (sr_cycle)
);

// File: tb/sbp_status_guard_bench.sv
`timescale 1ns/1ps
module sbp_status_guard_bench;
    localparam int AW  = 13;
    localparam int FBW = 10;

    logic           clk = 1'b0;
    logic           por_n, soft_rst_n, lock_pin_n;
    logic           frame_end;
    logic [2:0]     frame_kind;
    logic [FBW-1:0] frame_bits;
    logic           sr_loaded;
    logic [7:0]     sr_data;
    logic [AW-1:0]  wr_addr, q_addr;
    logic           wr_done, q_status;
    logic           q_allow, wel, wip, hw_lock, arr_cycle, sr_cycle;
    logic [7:0]     status_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sbp_status_guard #(.AW(AW), .FBW(FBW)) u_sbp_status_guard (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .lock_pin_n(lock_pin_n),
        .frame_end(frame_end), .frame_kind(frame_kind), .frame_bits(frame_bits),
        .sr_loaded(sr_loaded), .sr_data(sr_data), .wr_addr(wr_addr), .wr_done(wr_done),
        .q_addr(q_addr), .q_status(q_status), .q_allow(q_allow),
        .status_byte(status_byte), .wel(wel), .wip(wip), .hw_lock(hw_lock),
        .arr_cycle(arr_cycle), .sr_cycle(sr_cycle)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic frame(input logic [2:0] k, input int b);
        @(negedge clk);
        frame_end = 1'b1; frame_kind = k; frame_bits = FBW'(b);
        @(negedge clk);
        frame_end = 1'b0; frame_kind = 3'd0; frame_bits = '0;
    endtask

    task automatic load_sr(input logic [7:0] d);
        @(negedge clk);
        sr_loaded = 1'b1; sr_data = d;
        @(negedge clk);
        sr_loaded = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        wr_done = 1'b1;
        @(negedge clk);
        wr_done = 1'b0;
    endtask

    task automatic query(input logic st, input logic [AW-1:0] a);
        q_status = st; q_addr = a;
        #1;
    endtask

    task automatic t_reset();
        check("R1 por status", status_byte, 8'h00);
        query(1'b1, '0);
        check("R6 status query without latch", {7'd0, q_allow}, 8'h00);
    endtask

    task automatic t_latch();
        frame(3'd1, 7);
        check("R2 enable 7 bits", status_byte, 8'h00);
        frame(3'd1, 9);
        check("R2 enable 9 bits", status_byte, 8'h00);
        frame(3'd1, 8);
        check("R2 enable 8 bits", status_byte, 8'h02);
        frame(3'd2, 8);
        check("R3 disable", status_byte, 8'h00);
    endtask

    task automatic t_array();
        frame(3'd1, 8);
        wr_addr = 13'h0100;
        frame(3'd4, 36);
        check("R4 odd bit count", status_byte, 8'h02);
        frame(3'd4, 40);
        check("R4 write starts", status_byte, 8'hFF);
        check("R8 busy flag", {7'd0, wip}, 8'h01);
        frame(3'd1, 8);
        done_pulse();
        check("R9 R8 latch cleared, enable during busy ignored", status_byte, 8'h00);
        frame(3'd4, 32);
        check("R4 no latch no cycle", status_byte, 8'h00);
    endtask

    task automatic t_sr_write();
        frame(3'd1, 8);
        load_sr(8'hFF);
        frame(3'd3, 16);
        check("R7 status cycle starts", status_byte, 8'hFF);
        done_pulse();
        check("R9 masked status load", status_byte, 8'h8C);
        frame(3'd1, 8);
        query(1'b0, 13'h0000);
        check("R5 all guarded query", {7'd0, q_allow}, 8'h00);
        wr_addr = 13'h0000;
        frame(3'd4, 32);
        check("R5 guarded write refused", status_byte, 8'h8E);
        load_sr(8'h84);
        frame(3'd3, 16);
        done_pulse();
        check("R9 zone set to top quarter", status_byte, 8'h84);
    endtask

    task automatic t_lock();
        frame(3'd1, 8);
        check("R2 latch set", status_byte, 8'h86);
        query(1'b0, 13'h1800);
        check("R5 0x1800 guarded", {7'd0, q_allow}, 8'h00);
        query(1'b0, 13'h17FF);
        check("R5 0x17FF open", {7'd0, q_allow}, 8'h01);
        lock_pin_n = 1'b0;
        #1;
        check("R6 lock active", {7'd0, hw_lock}, 8'h01);
        query(1'b1, '0);
        check("R6 status query locked", {7'd0, q_allow}, 8'h00);
        query(1'b0, 13'h17FF);
        check("R6 open array still allowed", {7'd0, q_allow}, 8'h01);
        load_sr(8'h00);
        frame(3'd3, 16);
        check("R6 status write refused", status_byte, 8'h86);
        wr_addr = 13'h0000;
        frame(3'd4, 32);
        check("R6 array write under lock", status_byte, 8'hFF);
        done_pulse();
        check("R9 after array cycle", status_byte, 8'h84);
        lock_pin_n = 1'b1;
    endtask

    task automatic t_abort();
        frame(3'd1, 8);
        load_sr(8'h08);
        @(negedge clk); lock_pin_n = 1'b0;
        @(negedge clk); lock_pin_n = 1'b1;
        frame(3'd3, 16);
        check("R7 armed write dropped", status_byte, 8'h86);
        load_sr(8'h08);
        frame(3'd3, 16);
        check("R7 clean write starts", status_byte, 8'hFF);
        done_pulse();
        check("R9 pin enable cleared", status_byte, 8'h08);
    endtask

    task automatic t_half();
        frame(3'd1, 8);
        lock_pin_n = 1'b0;
        #1;
        check("R6 no lock with enable bit 0", {7'd0, hw_lock}, 8'h00);
        query(1'b1, '0);
        check("R6 status query allowed", {7'd0, q_allow}, 8'h01);
        query(1'b0, 13'h1000);
        check("R5 0x1000 guarded", {7'd0, q_allow}, 8'h00);
        query(1'b0, 13'h0FFF);
        check("R5 0x0FFF open", {7'd0, q_allow}, 8'h01);
        lock_pin_n = 1'b1;
    endtask

    task automatic t_resets();
        check("R10 before soft reset", status_byte, 8'h0A);
        @(negedge clk); soft_rst_n = 1'b0;
        @(negedge clk); soft_rst_n = 1'b1;
        check("R10 soft reset keeps nv bits", status_byte, 8'h08);
        frame(3'd1, 8);
        wr_addr = 13'h0000;
        frame(3'd4, 32);
        check("R4 write before soft reset", status_byte, 8'hFF);
        @(negedge clk); soft_rst_n = 1'b0;
        @(negedge clk); soft_rst_n = 1'b1;
        check("R10 soft reset ends cycle", status_byte, 8'h08);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        check("R10 por clears all", status_byte, 8'h00);
    endtask

    initial begin
        por_n = 1'b0; soft_rst_n = 1'b1; lock_pin_n = 1'b1;
        frame_end = 1'b0; frame_kind = 3'd0; frame_bits = '0;
        sr_loaded = 1'b0; sr_data = 8'h00; wr_addr = '0; wr_done = 1'b0;
        q_addr = '0; q_status = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_array();
        t_sr_write();
        t_lock();
        t_abort();
        t_half();
        t_resets();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule